// File: doc/BRIEF.md
# Open-Page DRAM Bank Controller

This block drives a single DRAM bank on behalf of a cache that fetches whole lines. Every accepted request names a row and a starting column. The controller turns it into precharge, row-activate and column-access commands and spaces them with programmable cycle delays. It also remembers which row is currently latched in the bank's page buffer. A request that lands in the open row skips straight to the column accesses. A request for another row first closes the open one. A request to a bank with no open row starts with the activation.

A line is four words. The words are fetched starting from the requested column and wrap within the aligned group of four, so the critical word comes first. In page mode every column access takes the full column delay. In burst mode the first access takes the column delay and the three that follow take the shorter burst delay. A close-page option precharges the bank after each line, so every request pays the same activation-based latency.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester holds `req_valid` and its fields steady until it sees `req_ready`, and that hold is the only back-pressure. The word strobe, the commands and `done` are plain pulses with no back-pressure, because a DRAM column access cannot be stalled.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset the bank is treated as precharged with no row open: `req_ready` is 1, and `cmd_pre`, `cmd_act`, `cmd_col`, `word_valid` and `done` are 0.
- R2: With no row open, an accepted request produces exactly one activate, no precharge and four column commands. `done` is seen in cycle r+4a, counting the cycle after the accepting edge as cycle 1.
- R3: With the requested row already open, only the four column commands are issued, with no precharge or activate, and `done` falls in cycle 4a.
- R4: With a different row open, the sequence is one precharge, then one activate, then four column commands, and `done` falls in cycle p+r+4a.
- R5: In burst mode (`burst_mode`=1) the column part costs a+3b cycles instead of 4a. The first column access takes a cycles and each later one takes b cycles.
- R6: Row and column share `addr`. In the cycle of `cmd_act` it carries the row. In the cycle of the k-th `cmd_col` (k=0..3) it carries the column whose bits [1:0] are (start+k) mod 4 and whose upper bits equal the request's. At most one command strobe is high in any cycle.
- R7: `word_valid` pulses exactly four times per request, in the last cycle of each column access. `word_idx` equals (start column bits [1:0] + k) mod 4 on the k-th pulse. `done` is high together with the fourth pulse only.
- R8: `req_ready` stays low from the accepting edge until the line is complete. In open-page mode it is high again in the cycle right after `done`.
- R9: With `close_page`=1, the cycle after `done` carries `cmd_pre`, and `req_ready` returns p+1 cycles after the `done` cycle. The next request then finds no row open.
- R10: A programmed delay of 0 behaves as a delay of 1.
- R11: Mode, close option and the four delays are captured when a request is accepted. Changing them during a transfer does not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line request offered |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_row | input | ROW_W | Row of the requested line |
| req_col | input | COL_W | Column of the first (critical) word |
| burst_mode | input | 1 | 1 selects burst column timing, 0 page mode |
| close_page | input | 1 | 1 precharges after each line |
| t_pre | input | TW | Precharge delay p in cycles |
| t_act | input | TW | Row-activate delay r in cycles |
| t_col | input | TW | Full column delay a in cycles |
| t_burst | input | TW | Burst beat delay b in cycles |
| cmd_pre | output | 1 | Precharge command strobe |
| cmd_act | output | 1 | Row-activate (row strobe) command |
| cmd_col | output | 1 | Column-access (column strobe) command |
| addr | output | ADDR_W | Shared row/column address lines |
| word_valid | output | 1 | A word of the line is available this cycle |
| word_idx | output | 2 | Position of that word within the line |
| done | output | 1 | Last word of the line |

## Verification
The bench goes after the three open-row cases on the same row and on a changed row, because a design whose open-row memory was off by one request would charge a hit as a miss, or skip the precharge and read the wrong page. Zero delays and all-ones delays are applied to catch a timer that wraps, or a count that runs one cycle long or short. The configuration inputs are scrambled right after acceptance to expose a design that reads them live. Close-page runs check that the trailing precharge keeps the controller busy for exactly p cycles and leaves the bank with no row open.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int LINE_WORDS = 4;
  localparam int BEAT_W = $clog2(LINE_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_CLOSE
  } dpc_state_t;
endpackage

// File: rtl/dpc_timer.sv
module dpc_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          last
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == TW'(1));
endmodule

// File: rtl/dpc_row_track.sv
module dpc_row_track #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             row_open,
  output logic             probe_hit
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (open_clr) begin
      row_open <= 1'b0;
    end else if (open_set) begin
      row_open <= 1'b1;
      open_row <= set_row;
    end
  end

  assign probe_hit = row_open && (open_row == probe_row);
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              row_open,
  input  logic              row_hit,
  input  logic              burst_mode,
  input  logic              close_page,
  input  logic [TW-1:0]     t_pre,
  input  logic [TW-1:0]     t_act,
  input  logic [TW-1:0]     t_col,
  input  logic [TW-1:0]     t_burst,
  input  logic              tmr_last,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              accept,
  output logic              cmd_pre,
  output logic              cmd_act,
  output logic              cmd_col,
  output logic              word_valid,
  output logic              done,
  output logic [BEAT_W-1:0] beat
);
  dpc_state_t st, st_n;
  logic [BEAT_W-1:0] beat_n;
  logic first, first_n;
  logic c_burst, c_close;
  logic [TW-1:0] c_pre, c_act, c_col, c_bt;

  function automatic logic [TW-1:0] nz(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_n     = st;
    beat_n   = beat;
    first_n  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = c_col;
    case (st)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        first_n  = 1'b1;
        beat_n   = '0;
        if (row_hit) begin
          st_n = ST_COL;  tmr_val = nz(t_col);
        end else if (row_open) begin
          st_n = ST_PRE;  tmr_val = nz(t_pre);
        end else begin
          st_n = ST_ACT;  tmr_val = nz(t_act);
        end
      end
      ST_PRE: if (tmr_last) begin
        st_n = ST_ACT; tmr_load = 1'b1; tmr_val = c_act; first_n = 1'b1;
      end
      ST_ACT: if (tmr_last) begin
        st_n = ST_COL; tmr_load = 1'b1; tmr_val = c_col; first_n = 1'b1;
      end
      ST_COL: if (tmr_last) begin
        if (beat == BEAT_W'(LINE_WORDS - 1)) begin
          if (c_close) begin
            st_n = ST_CLOSE; tmr_load = 1'b1; tmr_val = c_pre; first_n = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          beat_n   = beat + 1'b1;
          tmr_load = 1'b1;
          first_n  = 1'b1;
          tmr_val  = c_burst ? c_bt : c_col;
        end
      end
      ST_CLOSE: if (tmr_last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      beat  <= '0;
      first <= 1'b0;
    end else begin
      st    <= st_n;
      beat  <= beat_n;
      first <= first_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_burst <= 1'b0;
      c_close <= 1'b0;
      c_pre   <= TW'(1);
      c_act   <= TW'(1);
      c_col   <= TW'(1);
      c_bt    <= TW'(1);
    end else if (accept) begin
      c_burst <= burst_mode;
      c_close <= close_page;
      c_pre   <= nz(t_pre);
      c_act   <= nz(t_act);
      c_col   <= nz(t_col);
      c_bt    <= nz(t_burst);
    end
  end

  assign cmd_pre    = first && ((st == ST_PRE) || (st == ST_CLOSE));
  assign cmd_act    = first && (st == ST_ACT);
  assign cmd_col    = first && (st == ST_COL);
  assign word_valid = (st == ST_COL) && tmr_last;
  assign done       = word_valid && (beat == BEAT_W'(LINE_WORDS - 1));
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int TW    = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              burst_mode,
  input  logic              close_page,
  input  logic [TW-1:0]     t_pre,
  input  logic [TW-1:0]     t_act,
  input  logic [TW-1:0]     t_col,
  input  logic [TW-1:0]     t_burst,
  output logic              cmd_pre,
  output logic              cmd_act,
  output logic              cmd_col,
  output logic [ADDR_W-1:0] addr,
  output logic              word_valid,
  output logic [1:0]        word_idx,
  output logic              done
);
  logic              accept, row_open, row_hit, tmr_load, tmr_last;
  logic [TW-1:0]     tmr_val;
  logic [BEAT_W-1:0] beat;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [COL_W-1:0]  col_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_col;
    end
  end

  dpc_row_track #(.ROW_W(ROW_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .open_set(cmd_act), .open_clr(cmd_pre),
    .set_row(row_q), .probe_row(req_row),
    .row_open(row_open), .probe_hit(row_hit)
  );

  dpc_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .val(tmr_val), .last(tmr_last)
  );

  dpc_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .row_open(row_open), .row_hit(row_hit),
    .burst_mode(burst_mode), .close_page(close_page),
    .t_pre(t_pre), .t_act(t_act), .t_col(t_col), .t_burst(t_burst),
    .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .accept(accept),
    .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
    .word_valid(word_valid), .done(done), .beat(beat)
  );

  assign word_idx = col_q[1:0] + beat;
  assign col_addr = {col_q[COL_W-1:2], word_idx};

  always_comb begin
    if (cmd_act)      addr = ADDR_W'(row_q);
    else if (cmd_col) addr = ADDR_W'(col_addr);
    else              addr = '0;
  end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cmd_pre,
  input logic cmd_act,
  input logic cmd_col,
  input logic word_valid,
  input logic done
);
  logic       opened;
  logic [2:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opened <= 1'b0;
    else if (cmd_pre) opened <= 1'b0;
    else if (cmd_act) opened <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wcnt <= '0;
    else if (req_valid && req_ready) wcnt <= '0;
    else if (word_valid)             wcnt <= wcnt + 1'b1;
  end

  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre, cmd_act, cmd_col}));

  assert_col_needs_open_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> opened);

  assert_done_on_fourth_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_valid && wcnt == 3'd3));

  assert_no_ready_while_streaming_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !req_ready);

  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_col_after_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> !cmd_col);
endmodule

bind dram_page_ctrl dpc_checker u_dpc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
  .word_valid(word_valid), .done(done)
);

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
  localparam int ROW_W = 12, COL_W = 8, TW = 4, ADDR_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic burst_mode = 1'b0, close_page = 1'b0;
  logic [TW-1:0] t_pre = '0, t_act = '0, t_col = '0, t_burst = '0;
  logic cmd_pre, cmd_act, cmd_col, word_valid, done;
  logic [ADDR_W-1:0] addr;
  logic [1:0] word_idx;

  int errs = 0, checks = 0;
  bit m_open = 0;
  int m_row = 0;

  always #10 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .burst_mode(burst_mode),
    .close_page(close_page), .t_pre(t_pre), .t_act(t_act), .t_col(t_col),
    .t_burst(t_burst), .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
    .addr(addr), .word_valid(word_valid), .word_idx(word_idx), .done(done)
  );

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_req(input int row, input int col, input int bm, input int cl,
                         input int p, input int r, input int a, input int b);
    int c = 0, done_c = 0, npre = 0, nact = 0, ncol = 0, nw = 0, act_adr = 0;
    int bad_idx = 0, bad_adr = 0, d = 0, exp_l, exp_pre, exp_act;
    bit busy_bad = 0, hit, zflag;
    string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col);
    burst_mode = bm[0]; close_page = cl[0];
    t_pre = TW'(p); t_act = TW'(r); t_col = TW'(a); t_burst = TW'(b);
    @(posedge clk); #1;
    req_valid = 1'b0; req_row = ROW_W'($urandom);
    burst_mode = ~bm[0]; close_page = ~cl[0];
    t_pre = TW'($urandom); t_act = TW'($urandom); t_col = TW'($urandom); t_burst = TW'($urandom);

    hit = m_open && (m_row == row);
    zflag = (p == 0) || (r == 0) || (a == 0) || (b == 0);
    exp_pre = (m_open && !hit) ? 1 : 0;
    exp_act = hit ? 0 : 1;
    exp_l = (hit ? 0 : ((exp_pre ? nz(p) : 0) + nz(r))) +
            (bm != 0 ? nz(a) + 3 * nz(b) : 4 * nz(a));
    tag = hit ? "R3" : (m_open ? "R4" : "R2");
    if (bm != 0) tag = {tag, "/R5"};
    if (zflag)   tag = {tag, "/R10"};

    while (done_c == 0 && c < 2000) begin
      @(negedge clk);
      c++;
      if (req_ready) busy_bad = 1;
      if (cmd_pre) npre++;
      if (cmd_act) begin nact++; act_adr = int'(addr); end
      if (cmd_col) begin
        if (int'(addr) != ((col & ~3) | ((col + ncol) & 3))) bad_adr++;
        ncol++;
      end
      if (word_valid) begin
        if (int'(word_idx) != ((col + nw) & 3)) bad_idx++;
        nw++;
      end
      if (done) done_c = c;
    end

    chk(done_c == exp_l, {tag, "/R11 done cycle"}, done_c, exp_l);
    chk(npre == exp_pre, {tag, " precharge count"}, npre, exp_pre);
    chk(nact == exp_act, {tag, " activate count"}, nact, exp_act);
    chk(ncol == 4, "R2 column command count", ncol, 4);
    chk(nw == 4, "R7 word strobe count", nw, 4);
    chk(bad_idx == 0, "R7 word index order", bad_idx, 0);
    chk(bad_adr == 0, "R6 column address", bad_adr, 0);
    if (exp_act == 1) chk(act_adr == row, "R6 row address", act_adr, row);
    chk(!busy_bad, "R8 ready low while busy", int'(busy_bad), 0);

    do begin
      @(negedge clk);
      d++;
      if (cl != 0 && d == 1) chk(cmd_pre == 1'b1, "R9 trailing precharge", int'(cmd_pre), 1);
    end while (!req_ready && d < 100);
    chk(d == (cl != 0 ? nz(p) + 1 : 1), cl != 0 ? "R9 ready return" : "R8 ready return",
        d, cl != 0 ? nz(p) + 1 : 1);

    if (cl != 0) m_open = 0;
    else begin m_open = 1; m_row = row; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk({cmd_pre, cmd_act, cmd_col} == 3'b000, "R1 no command after reset",
        int'({cmd_pre, cmd_act, cmd_col}), 0);
    chk(word_valid == 1'b0 && done == 1'b0, "R1 no word after reset",
        int'({word_valid, done}), 0);

    run_req(5, 2, 0, 0, 3, 4, 2, 1);    // R2 bank closed
    run_req(5, 1, 0, 0, 3, 4, 2, 1);    // R3 hit
    run_req(9, 7, 0, 0, 3, 4, 2, 1);    // R4 miss
    run_req(9, 4, 1, 0, 2, 2, 3, 1);    // R5 burst hit
    run_req(7, 3, 1, 0, 2, 3, 4, 2);    // R5 burst miss
    run_req(7, 0, 0, 1, 5, 2, 1, 1);    // R9 hit then close
    run_req(7, 6, 0, 1, 5, 2, 1, 1);    // R9 closed again
    run_req(3, 5, 1, 0, 0, 0, 0, 0);    // R10 zero delays
    run_req(3, 9, 0, 0, 0, 0, 0, 0);    // R10 hit, zero delays
    run_req(11, 255, 1, 0, 15, 15, 15, 15); // long delays, wrap

    for (int i = 0; i < 60; i++) begin
      run_req(1 + int'($urandom % 3), int'($urandom % 256), int'($urandom % 2),
              ($urandom % 4 == 0) ? 1 : 0, int'($urandom % 8), int'($urandom % 8),
              int'($urandom % 8), int'($urandom % 8));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule